// File: doc/BRIEF.md
# Power-Up Reset and Supply Sequencer

This block keeps a device in reset while its supplies come up. It takes one supply-good flag for each of eight I/O banks, one flag for the I/O pre-driver supply and one for the core supply. It starts configuration only when all ten flags are good together and a power-up wait has elapsed. The wait is either short (12 ms) or long (100 ms), and a select pin chooses between them. Global reset and the user I/O tri-state stay asserted until the configuration engine reports that it has finished.

The block also limits how long a ramp may take. If the supplies are not all good within 100 ms of the start of a ramp, it raises an error flag and keeps the device in reset until a supply falls and a fresh ramp begins. In user mode it watches only the core supply. If that supply drops, the sequence goes back to the start.

All times are counted in clock cycles. The cycles per millisecond come from a clock-frequency parameter, and an override parameter can replace that figure so that simulation runs with short windows. In the text below, CPM means cycles per millisecond.

Top module: `por_sequencer`

## Requirements
- R1: Every supply-good input and the delay-select input pass through two flip-flops. A change on one of these inputs reaches the outputs at the third rising clock edge after it is applied, and no earlier.
- R2: While `rst` is high and just after it falls, `rst_out` and `tri_out` are 1, and `cfg_start` and `rise_err` are 0.
- R3: `cfg_start` is issued only while `rst_out` is still 1. With the delay select held steady, it rises exactly DELAY+3 rising edges after the last of the ten supply flags goes high.
- R4: DELAY is 100*CPM cycles when the synchronized delay select is 0, and 12*CPM cycles when it is 1.
- R5: The delay select is captured once, on the edge that leaves the ramp phase. Later changes to it have no effect on that power-up.
- R6: `cfg_start` is high for exactly one clock cycle.
- R7: `rst_out` and `tri_out` fall together on the first rising edge at which `cfg_done` is 1 after `cfg_start` was issued. A `cfg_done` that comes before `cfg_start` has no effect.
- R8: If the ten flags are not all good, `rise_err` rises on the 100*CPM-th rising edge after the ramp began. The ramp begins when reset is released, when a supply is lost, or when the error is re-armed.
- R9: While `rise_err` is 1, the block stays in reset and issues no `cfg_start`, even if all supplies are good. A falling edge on any synchronized supply flag clears `rise_err` and starts a new ramp window.
- R10: In user mode, the bank flags and the pre-driver flag are ignored, and `rst_out` stays 0.
- R11: If the core flag falls in user mode, `rst_out` and `tri_out` return to 1. The sequence then restarts with a full rise window and a full delay.
- R12: Losing any supply flag during the delay phase or while waiting for `cfg_done` returns the block to the ramp phase. The delay then starts over once all flags are good again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_ok | input | N_BANKS | Supply-good flag for each I/O bank |
| drv_ok | input | 1 | Pre-driver supply-good flag |
| core_ok | input | 1 | Core supply-good flag |
| dly_sel | input | 1 | Delay select: 0 selects the long wait, 1 selects the short wait |
| cfg_done | input | 1 | Configuration finished |
| rst_out | output | 1 | Global reset to the device |
| tri_out | output | 1 | Tri-state enable for the user I/O |
| cfg_start | output | 1 | One-cycle request to start configuration |
| rise_err | output | 1 | Supply rise window expired |

## Verification
The hardest state to reach is the error-recovery path. To get there, the rise window must expire, then every supply must come good while the block still refuses to start, and then one flag must fall to re-arm it. The bench runs exactly that sequence, using shortened windows. It also checks that the error flag clears on the third edge after the fall, and that a complete power-up follows. Random supply orderings with random gaps show that the start pulse always falls at the same cycle after the last flag rises. Directed cases change the delay select in the middle of the delay phase, and pulse `cfg_done` before configuration has started.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_RAMP  = 2'd0,
    ST_DELAY = 2'd1,
    ST_CFG   = 2'd2,
    ST_USER  = 2'd3
  } por_state_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end
    assign dout[i] = sync_q;
  end
endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign hit = en && (cnt_q == (limit - W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en && !hit) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_pkg::*;
#(
  parameter int CLK_HZ         = 100_000_000,
  parameter int N_BANKS        = 8,
  parameter int CYC_PER_MS_OVR = 0,
  parameter int SHORT_MS       = 12,
  parameter int LONG_MS        = 100,
  parameter int RISE_MS        = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_BANKS-1:0] bank_ok,
  input  logic               drv_ok,
  input  logic               core_ok,
  input  logic               dly_sel,
  input  logic               cfg_done,
  output logic               rst_out,
  output logic               tri_out,
  output logic               cfg_start,
  output logic               rise_err
);
  localparam int CPM     = (CYC_PER_MS_OVR != 0) ? CYC_PER_MS_OVR : CLK_HZ / 1000;
  localparam int SHORT_C = SHORT_MS * CPM;
  localparam int LONG_C  = LONG_MS * CPM;
  localparam int RISE_C  = RISE_MS * CPM;
  localparam int MAX_DL  = (SHORT_C > LONG_C) ? SHORT_C : LONG_C;
  localparam int MAX_C   = (MAX_DL > RISE_C) ? MAX_DL : RISE_C;
  localparam int CW      = $clog2(MAX_C + 1);
  localparam int NSUP    = N_BANKS + 2;
  localparam int NSYNC   = NSUP + 1;
  localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_C);
  localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_C);
  localparam logic [CW-1:0] LIM_RISE  = CW'(RISE_C);

  logic [NSYNC-1:0] s_vec;
  logic [NSUP-1:0]  sup, sup_q;
  logic             s_core, s_sel, all_ok, any_fall;
  por_state_t       state_q, nxt;
  logic             sel_q, err_q;
  logic             rise_hit, dly_hit;

  por_sync #(.WIDTH(NSYNC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({dly_sel, core_ok, drv_ok, bank_ok}),
    .dout (s_vec)
  );

  assign sup      = s_vec[NSUP-1:0];
  assign s_core   = s_vec[N_BANKS+1];
  assign s_sel    = s_vec[NSYNC-1];
  assign all_ok   = &sup;
  assign any_fall = |(sup_q & ~sup);

  por_timer #(.W(CW)) u_rise (
    .clk   (clk),
    .rst   (rst),
    .clr   ((state_q != ST_RAMP) || (err_q && any_fall)),
    .en    ((state_q == ST_RAMP) && !all_ok && !err_q),
    .limit (LIM_RISE),
    .hit   (rise_hit)
  );

  por_timer #(.W(CW)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .clr   (state_q != ST_DELAY),
    .en    ((state_q == ST_DELAY) && all_ok),
    .limit (sel_q ? LIM_SHORT : LIM_LONG),
    .hit   (dly_hit)
  );

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_RAMP:  if (!err_q && all_ok) nxt = ST_DELAY;
      ST_DELAY: if (!all_ok) nxt = ST_RAMP;
                else if (dly_hit) nxt = ST_CFG;
      ST_CFG:   if (!all_ok) nxt = ST_RAMP;
                else if (cfg_done) nxt = ST_USER;
      ST_USER:  if (!s_core) nxt = ST_RAMP;
      default:  nxt = ST_RAMP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RAMP;
      sup_q     <= '0;
      sel_q     <= 1'b0;
      err_q     <= 1'b0;
      rst_out   <= 1'b1;
      tri_out   <= 1'b1;
      cfg_start <= 1'b0;
    end else begin
      state_q   <= nxt;
      sup_q     <= sup;
      if (state_q == ST_RAMP && nxt == ST_DELAY) sel_q <= s_sel;
      if (err_q && any_fall) err_q <= 1'b0;
      else if (rise_hit)     err_q <= 1'b1;
      rst_out   <= (nxt != ST_USER);
      tri_out   <= (nxt != ST_USER);
      cfg_start <= (state_q == ST_DELAY) && (nxt == ST_CFG);
    end
  end

  assign rise_err = err_q;
endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic cfg_start,
  input logic rst_out,
  input logic tri_out,
  input logic rise_err,
  input logic cfg_done,
  input logic core_sync
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst) cfg_start |=> !cfg_start); // R6
  AST_START_IN_RESET: assert property (@(posedge clk) disable iff (rst) cfg_start |-> rst_out); // R3
  AST_RST_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst) $fell(rst_out) |-> $past(cfg_done)); // R7
  AST_TRI_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst) $fell(tri_out) |-> $past(cfg_done)); // R7
  AST_ERR_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst) rise_err |-> (rst_out && !cfg_start)); // R9
  AST_BROWNOUT_RESET: assert property (@(posedge clk) disable iff (rst) (!rst_out && !core_sync) |=> rst_out); // R11
endmodule

bind por_sequencer por_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_start (cfg_start),
  .rst_out   (rst_out),
  .tri_out   (tri_out),
  .rise_err  (rise_err),
  .cfg_done  (cfg_done),
  .core_sync (s_core)
);

// File: tb/por_sequencer_test.sv
module por_sequencer_test;
  localparam int CPM  = 2;
  localparam int RISE = 100 * CPM;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bank_ok = '0;
  logic       drv_ok = 1'b0, core_ok = 1'b0, dly_sel = 1'b0, cfg_done = 1'b0;
  logic       rst_out, tri_out, cfg_start, rise_err;
  int n_chk = 0, n_fail = 0, n_starts = 0;

  always #5 clk = ~clk;

  por_sequencer #(.CYC_PER_MS_OVR(CPM)) uut (
    .clk(clk), .rst(rst), .bank_ok(bank_ok), .drv_ok(drv_ok), .core_ok(core_ok),
    .dly_sel(dly_sel), .cfg_done(cfg_done), .rst_out(rst_out), .tri_out(tri_out),
    .cfg_start(cfg_start), .rise_err(rise_err)
  );

  always @(negedge clk) if (cfg_start) n_starts++;

  function automatic int exp_cfg(input logic sel);
    return (sel ? 12 : 100) * CPM + 3;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bank_ok = '0; drv_ok = 0; core_ok = 0; cfg_done = 0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic all_up();
    bank_ok = '1; drv_ok = 1'b1; core_ok = 1'b1;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!cfg_start && n < 2000) begin
      tick();
      n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, seed, gap, idx, n0;
    logic [9:0] pend;
    logic sel;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();
    // R2 reset state
    check(rst_out && tri_out && !cfg_start && !rise_err, "R2", {rst_out, tri_out, cfg_start, rise_err}, 4'b1100);

    // R8 rise window expiry at exactly RISE edges
    tick(RISE - 1);
    check(rise_err == 0, "R8 before window", rise_err, 0);
    tick();
    check(rise_err == 1, "R8 at window", rise_err, 1);

    // R9 stuck in reset with error even with supplies good
    n0 = n_starts;
    dly_sel = 1'b1;
    all_up();
    tick(300);
    check(rst_out && rise_err && n_starts == n0, "R9 held", n_starts - n0, 0);
    bank_ok[3] = 1'b0;
    tick(2);
    check(rise_err == 1, "R1 err before third edge", rise_err, 1);
    tick();
    check(rise_err == 0, "R9 re-arm on fall", rise_err, 0);
    bank_ok[3] = 1'b1;
    wait_start(n);
    check(n == exp_cfg(1), "R9 start after re-arm", n, exp_cfg(1));
    tick();
    check(cfg_start == 0, "R6 pulse width", cfg_start, 0);

    // R7 release on cfg_done
    tick(4);
    check(rst_out && tri_out, "R7 held in config", rst_out, 1);
    cfg_done = 1'b1;
    tick();
    cfg_done = 1'b0;
    check(!rst_out && !tri_out, "R7 release", {rst_out, tri_out}, 0);

    // R10 non-core flags ignored in user mode
    bank_ok[0] = 1'b0; drv_ok = 1'b0;
    tick(10);
    check(!rst_out && !tri_out, "R10 ignore flags", rst_out, 0);
    bank_ok[0] = 1'b1; drv_ok = 1'b1;
    tick(3);

    // R11 brownout, R1 latency
    dly_sel = 1'b0;
    core_ok = 1'b0;
    tick(2);
    check(rst_out == 0, "R1 brownout not before third edge", rst_out, 0);
    tick();
    check(rst_out && tri_out, "R11 brownout reset", {rst_out, tri_out}, 2'b11);
    core_ok = 1'b1;
    wait_start(n);
    check(n == exp_cfg(0), "R11 full restart R4 long", n, exp_cfg(0));

    // R12 supply loss in delay, R7 early cfg_done ignored
    do_reset();
    dly_sel = 1'b1;
    all_up();
    tick(10);
    cfg_done = 1'b1;
    tick(3);
    cfg_done = 1'b0;
    check(rst_out == 1, "R7 early done ignored", rst_out, 1);
    drv_ok = 1'b0;
    tick(4);
    drv_ok = 1'b1;
    wait_start(n);
    check(n == exp_cfg(1), "R12 delay restarts R4 short", n, exp_cfg(1));

    // R5 select captured on leaving ramp
    do_reset();
    dly_sel = 1'b0;
    all_up();
    tick(5);
    dly_sel = 1'b1;
    wait_start(n);
    check(n + 5 == exp_cfg(0), "R5 select held", n + 5, exp_cfg(0));

    // R3 random supply orderings
    for (int it = 0; it < 10; it++) begin
      do_reset();
      sel = 1'($urandom % 2);
      dly_sel = sel;
      pend = '1;
      while (pend != 0) begin
        gap = int'($urandom % 6);
        tick(gap);
        idx = int'($urandom % 10);
        while (!pend[idx]) idx = (idx + 1) % 10;
        pend[idx] = 1'b0;
        if (idx < 8) bank_ok[idx] = 1'b1;
        else if (idx == 8) drv_ok = 1'b1;
        else core_ok = 1'b1;
      end
      n0 = n_starts;
      wait_start(n);
      check(n == exp_cfg(sel), "R3 start timing", n, exp_cfg(sel));
      check(rise_err == 0 && rst_out == 1, "R8 no error within window", rise_err, 0);
      tick(int'($urandom % 8));
      cfg_done = 1'b1;
      tick();
      cfg_done = 1'b0;
      check(rst_out == 0 && n_starts == n0 + 1, "R7 random release", rst_out, 0);
    end

    finish_run();
  end
endmodule